// File: doc/BRIEF.md
# Configurable Multi-Mode I/O Port

This block is an eight-pin general-purpose port for a microcontroller peripheral device. Each pin picks its own mode, so one port can mix several uses at once. A pin can be plain I/O owned by the MCU, or a pin of the programmable logic array. It can also drive a latched address bit, capture an address bit from a multiplexed bus, or (on the low four pins) carry a timer output. The pad is modelled as separate input, output and output-enable signals. The output enable comes from a per-pin direction bit.

The MCU reaches the port through a small synchronous register interface. Five registers can be written: data-out, direction, and three mode planes. The three mode planes together give each pin a 3-bit mode code. A sixth register returns the synchronized pin levels and is read-only. Address bytes come from a 16-bit multiplexed address/data bus and are latched while the address strobe is high. The `PORT_B` parameter picks the variant. The B variant places the high address byte on the pins when the bus is 16-bit multiplexed. The B variant also has no address-input mode.

Top module: `cfg_io_port`

## Requirements
- R1: After reset all registers read 0, every pin_oe bit is 0, pin_out is 0 and addr_in and pld_in are 0.
- R2: A write to register 0 (data-out), 1 (direction), 2, 3 or 4 (mode planes 0, 1, 2) takes effect on the next rising clock edge, and a read returns the last value written. A write to register 5 (data-in) has no effect on what it reads.
- R3: pin_oe[n] equals direction bit n.
- R4: Each pin's mode code is {plane2[n], plane1[n], plane0[n]}. Code 0 (MCU I/O) drives pin_out[n] from data-out bit n.
- R5: Code 1 (logic-array I/O) drives pin_out[n] from pld_out[n]. In this mode pld_in[n] carries the synchronized pin level; pld_in[n] is 0 in every other mode.
- R6: Code 2 (address out) on the A variant drives pin n with latched address bit n. The address latch loads ad_bus on every clock edge where ale is 1, holds while ale is 0, and is cleared by reset.
- R7: On the B variant, code 2 drives pin n with latched address bit n when bus_16 is 0, and with bit n+8 when bus_16 is 1.
- R8: Code 4 (timer out) drives pin n from timer_out[n] for pins 0 to 3. On pins 4 to 7, code 4 has no effect and the pin behaves as code 0.
- R9: Code 3 (address in, A variant only) makes addr_in[n] show the synchronized pin level captured on the last clock edge with ale at 1; the value holds while ale is 0. addr_in[n] is 0 in other modes. On the B variant, addr_in is always 0 and code 3 behaves as code 0.
- R10: A read of register 5 returns pin_in delayed by two clock edges, whatever mode each pin is in.
- R11: Modes are independent per pin: pins with different codes drive their own sources in the same cycle.
- R12: Codes 5, 6 and 7 behave as code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| ad_bus | input | 16 | Multiplexed address/data bus |
| ale | input | 1 | Address latch strobe, active high |
| bus_16 | input | 1 | 1 when the bus is 16-bit multiplexed |
| pld_out | input | 8 | Per-pin output from the logic array |
| pld_in | output | 8 | Per-pin input to the logic array |
| addr_in | output | 8 | Captured address bits from the pins |
| timer_out | input | 4 | Timer outputs for pins 0 to 3 |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |

## Verification
The bench builds two copies side by side from the same stimulus: one with `PORT_B` at 0 and one with `PORT_B` at 1. The A copy exercises the address-input capture and low-byte address output. The B copy is needed to see the byte placement switch with `bus_16` and to confirm that code 3 falls back to MCU I/O with `addr_in` held at zero. Both copies use the default eight pins with four timer-capable pins, so the boundary between pins 3 and 4 in timer mode is observed directly.

// File: rtl/cfg_io_port.sv
module cfg_io_port #(
  parameter bit PORT_B      = 1'b0,
  parameter int NPINS       = 8,
  parameter int TMR_PINS    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [2:0]         reg_addr,
  input  logic [NPINS-1:0]   reg_wdata,
  output logic [NPINS-1:0]   reg_rdata,
  input  logic [2*NPINS-1:0] ad_bus,
  input  logic               ale,
  input  logic               bus_16,
  input  logic [NPINS-1:0]   pld_out,
  output logic [NPINS-1:0]   pld_in,
  output logic [NPINS-1:0]   addr_in,
  input  logic [TMR_PINS-1:0] timer_out,
  input  logic [NPINS-1:0]   pin_in,
  output logic [NPINS-1:0]   pin_out,
  output logic [NPINS-1:0]   pin_oe
);

  localparam int AW = 2 * NPINS;
  localparam logic [2:0] RG_DOUT = 3'd0;
  localparam logic [2:0] RG_DIR  = 3'd1;
  localparam logic [2:0] RG_M0   = 3'd2;
  localparam logic [2:0] RG_M1   = 3'd3;
  localparam logic [2:0] RG_M2   = 3'd4;
  localparam logic [2:0] RG_DIN  = 3'd5;
  localparam logic [2:0] MD_PLD  = 3'd1;
  localparam logic [2:0] MD_AOUT = 3'd2;
  localparam logic [2:0] MD_AIN  = 3'd3;
  localparam logic [2:0] MD_TMR  = 3'd4;

  logic [NPINS-1:0] dout_q, dir_q, m0_q, m1_q, m2_q, ain_q;
  logic [AW-1:0]    alat_q;
  logic [SYNC_STAGES-1:0][NPINS-1:0] sync_q;
  logic [NPINS-1:0] pins_s;

  assign pins_s = sync_q[SYNC_STAGES-1];
  assign pin_oe = dir_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout_q <= '0;
      dir_q  <= '0;
      m0_q   <= '0;
      m1_q   <= '0;
      m2_q   <= '0;
      ain_q  <= '0;
      alat_q <= '0;
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_in};
      if (ale) begin
        alat_q <= ad_bus;
        ain_q  <= pins_s;
      end
      if (reg_wr) begin
        case (reg_addr)
          RG_DOUT: dout_q <= reg_wdata;
          RG_DIR:  dir_q  <= reg_wdata;
          RG_M0:   m0_q   <= reg_wdata;
          RG_M1:   m1_q   <= reg_wdata;
          RG_M2:   m2_q   <= reg_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_addr)
      RG_DOUT: reg_rdata = dout_q;
      RG_DIR:  reg_rdata = dir_q;
      RG_M0:   reg_rdata = m0_q;
      RG_M1:   reg_rdata = m1_q;
      RG_M2:   reg_rdata = m2_q;
      RG_DIN:  reg_rdata = pins_s;
      default: reg_rdata = '0;
    endcase
  end

  wire unused_ok = &{1'b0, bus_16, alat_q[AW-1:NPINS]};

  for (genvar n = 0; n < NPINS; n++) begin : g_pin
    logic [2:0] code;
    logic is_pld, is_aout, is_ain, is_tmr, abit, tbit;

    assign code    = {m2_q[n], m1_q[n], m0_q[n]};
    assign is_pld  = (code == MD_PLD);
    assign is_aout = (code == MD_AOUT);
    assign is_ain  = (code == MD_AIN) && !PORT_B;

    if (n < TMR_PINS) begin : g_tmr
      assign is_tmr = (code == MD_TMR);
      assign tbit   = timer_out[n];
    end else begin : g_notmr
      assign is_tmr = 1'b0;
      assign tbit   = 1'b0;
    end

    if (PORT_B) begin : g_b
      assign abit = bus_16 ? alat_q[n+NPINS] : alat_q[n];
    end else begin : g_a
      assign abit = alat_q[n];
    end

    assign pin_out[n] = is_pld  ? pld_out[n] :
                        is_aout ? abit       :
                        is_tmr  ? tbit       : dout_q[n];
    assign pld_in[n]  = is_pld & pins_s[n];
    assign addr_in[n] = is_ain & ain_q[n];

    if (n >= TMR_PINS) begin : g_hi_chk
      assert_hi_timer_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (code == MD_TMR) |-> (pin_out[n] == dout_q[n]));
    end
  end

  assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == RG_DIR) |=> (pin_oe == $past(reg_wdata)));

  assert_reset_oe_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (pin_oe == '0));

  assert_alat_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ale |=> $stable(alat_q));

  assert_ain_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ale |=> $stable(ain_q));

  assert_portb_no_ain_R9: assert property (@(posedge clk) disable iff (!rst_n)
    PORT_B |-> (addr_in == '0));

endmodule

// File: tb/cfg_io_port_tb.sv
module cfg_io_port_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [2:0]  reg_addr;
  logic [7:0]  reg_wdata;
  logic [7:0]  rdata_a, rdata_b;
  logic [15:0] ad_bus;
  logic        ale, bus_16;
  logic [7:0]  pld_out, pin_in;
  logic [3:0]  timer_out;
  logic [7:0]  pld_in_a, pld_in_b, ain_a, ain_b;
  logic [7:0]  out_a, out_b, oe_a, oe_b;
  int total = 0;
  int fails = 0;

  always #4 clk = ~clk;

  cfg_io_port #(.PORT_B(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata_a), .ad_bus(ad_bus), .ale(ale),
    .bus_16(bus_16), .pld_out(pld_out), .pld_in(pld_in_a), .addr_in(ain_a),
    .timer_out(timer_out), .pin_in(pin_in), .pin_out(out_a), .pin_oe(oe_a));

  cfg_io_port #(.PORT_B(1'b1)) u_dut_b (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata_b), .ad_bus(ad_bus), .ale(ale),
    .bus_16(bus_16), .pld_out(pld_out), .pld_in(pld_in_b), .addr_in(ain_b),
    .timer_out(timer_out), .pin_in(pin_in), .pin_out(out_b), .pin_oe(oe_b));

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [2:0] a, input logic [7:0] exp);
    reg_addr = a;
    #1;
    chk(tag, {8'h0, rdata_a}, {8'h0, exp});
  endtask

  task automatic modes(input logic [7:0] p0, input logic [7:0] p1, input logic [7:0] p2);
    wr(3'd2, p0); wr(3'd3, p1); wr(3'd4, p2);
  endtask

  task automatic ale_pulse(input logic [15:0] a);
    @(negedge clk);
    ad_bus = a; ale = 1'b1;
    @(negedge clk);
    ale = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    ad_bus = 16'h5555; ale = 1'b0; bus_16 = 1'b0; pld_out = '0;
    pin_in = '0; timer_out = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 oe", {8'h0, oe_a}, 16'h0);
    chk("R1 out", {out_b, out_a}, 16'h0);
    chk("R1 addr_in/pld_in", {ain_a, pld_in_a}, 16'h0);
    for (int a = 0; a < 6; a++) rd("R1 regs", a[2:0], 8'h00);
  endtask

  task automatic t_regs;
    wr(3'd0, 8'hA5);
    rd("R2 dout", 3'd0, 8'hA5);
    wr(3'd1, 8'h3C);
    rd("R2 dir", 3'd1, 8'h3C);
    chk("R3 oe", {oe_b, oe_a}, 16'h3C3C);
    wr(3'd5, 8'hFF);
    rd("R2 din ignored", 3'd5, 8'h00);
    chk("R4 mcu out", {out_b, out_a}, 16'hA5A5);
  endtask

  task automatic t_pld;
    modes(8'hFF, 8'h00, 8'h00);
    rd("R2 plane0", 3'd2, 8'hFF);
    @(negedge clk);
    pld_out = 8'h5A; pin_in = 8'h0F;
    repeat (2) @(negedge clk);
    chk("R5 pld out", {8'h0, out_a}, 16'h005A);
    chk("R5 pld in", {pld_in_b, pld_in_a}, 16'h0F0F);
    rd("R10 din in pld mode", 3'd5, 8'h0F);
    modes(8'h00, 8'h00, 8'h00);
    chk("R5 pld_in off", {8'h0, pld_in_a}, 16'h0);
  endtask

  task automatic t_aout;
    modes(8'h00, 8'hFF, 8'h00);
    ale_pulse(16'h1234);
    chk("R6 addr out A", {8'h0, out_a}, 16'h0034);
    chk("R7 B 8-bit", {8'h0, out_b}, 16'h0034);
    bus_16 = 1'b1; #1;
    chk("R7 B 16-bit", {8'h0, out_b}, 16'h0012);
    bus_16 = 1'b0;
    ad_bus = 16'hFFFF;
    repeat (3) @(negedge clk);
    chk("R6 hold", {8'h0, out_a}, 16'h0034);
  endtask

  task automatic t_tmr;
    modes(8'h00, 8'h00, 8'hFF);
    wr(3'd0, 8'h00);
    timer_out = 4'hF; #1;
    chk("R8 timer low", {8'h0, out_a}, 16'h000F);
    wr(3'd0, 8'hF0);
    timer_out = 4'h5; #1;
    chk("R8 timer high ignored", {out_b, out_a}, 16'hF5F5);
  endtask

  task automatic t_ain;
    modes(8'hFF, 8'hFF, 8'h00);
    wr(3'd0, 8'h66);
    pin_in = 8'hC3;
    repeat (2) @(negedge clk);
    ale_pulse(16'h0000);
    chk("R9 capture", {8'h0, ain_a}, 16'h00C3);
    chk("R9 B none", {ain_b, out_b}, 16'h0066);
    pin_in = 8'h11;
    repeat (3) @(negedge clk);
    chk("R9 hold", {8'h0, ain_a}, 16'h00C3);
    rd("R10 din", 3'd5, 8'h11);
  endtask

  task automatic t_mixed;
    modes(8'h02, 8'h24, 8'h28);
    wr(3'd0, 8'h20);
    pld_out = 8'h02; timer_out = 4'h8;
    ale_pulse(16'h0004);
    chk("R11 mixed ones", {8'h0, out_a}, 16'h002E);
    chk("R12 code6 mcu", {15'h0, out_a[5]}, 16'h1);
    wr(3'd0, 8'hDF);
    pld_out = 8'hFD; timer_out = 4'h7;
    ale_pulse(16'hFFFB);
    chk("R11 mixed zeros", {8'h0, out_a}, 16'h00D1);
  endtask

  initial begin
    #(8 * 200000);
    fails++; total++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    t_reset();
    t_regs();
    t_pld();
    t_aout();
    t_tmr();
    t_ain();
    t_mixed();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule